// File: doc/BRIEF.md
# Stream Prefetch and Write-Posting Engine

This block moves a sequential data stream between a DMA-facing buffer port and an external memory access engine. It works on one chip-select target at a time and never produces an address: every request it raises names only the target. A 64-byte FIFO of 16 words of 32 bits sits between the two sides. In prefetch mode the engine reads words from the device into the FIFO ahead of the consumer. In posting mode it drains words that the DMA has written into the FIFO out to the device.

Software programs a direction, a target chip-select and a byte count, then pulses start. The engine runs until the programmed number of words has crossed the access-engine port, then goes idle. A DMA request line paces the DMA from the FIFO fill level. The engine shares the access engine with host traffic through a small arbiter. Host requests win by default, but an engine that has watched a programmable number of host transfers go by while it waited is served once.

Top module: `stream_prefetch_post`

## Requirements
- R1: After reset, busy_o, dma_req_o, acc_req_o and host_gnt_o are all low.
- R2: A cfg_start_i pulse while busy_o is low latches cfg_mode_i (0 = prefetch, 1 = posting), cfg_cs_i and a word count of cfg_bytes_i divided by 4, rounded down, and clears the FIFO. A start whose word count is zero, or a start while busy_o is high, has no effect.
- R3: An engine request drives acc_cs_o to the latched chip-select and acc_we_o to 1 in posting mode and 0 in prefetch mode. A host request drives acc_cs_o and acc_we_o to the host_cs_i and host_we_i values present when it was selected.
- R4: A word moves only in a cycle where acc_req_o and acc_ack_i are both high. While acc_req_o is high and acc_ack_i is low, acc_req_o, acc_cs_o and acc_we_o hold. host_gnt_o is high exactly in the cycles where a host request completes.
- R5: When no access is outstanding, the engine is selected if it is eligible and either host_req_i is low or the starvation count is at least cfg_starve_i; otherwise a pending host request is selected. The starvation count rises by one, saturating at 15, for each completed host access while the engine is eligible, and clears when the engine is selected. After each completed access, acc_req_o is low for one cycle.
- R6: In prefetch mode, words returned on acc_rdata_i appear on sys_rdata_o in arrival order, and sys_rd_i removes the head. The engine is not eligible while the FIFO holds 16 words. sys_rd_i on an empty FIFO is ignored.
- R7: In posting mode, words accepted from sys_wdata_i leave on acc_wdata_o in the order they were written. The engine is not eligible while the FIFO is empty.
- R8: In prefetch mode, dma_req_o is high when the occupancy is at least max(cfg_thresh_i, 1), or when all words have been fetched and the FIFO is not empty.
- R9: In posting mode, dma_req_o is high when words remain to be accepted and the free space is at least max(cfg_thresh_i, 1). sys_wr_i is ignored when the FIFO is full, when all programmed words have been accepted, or when the engine is in prefetch mode.
- R10: busy_o is high exactly while engine transfers remain. It falls only after the last of exactly (cfg_bytes_i / 4) engine transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_start_i | input | 1 | Start pulse |
| cfg_mode_i | input | 1 | 0 = prefetch, 1 = posting |
| cfg_cs_i | input | 3 | Target chip-select |
| cfg_bytes_i | input | 16 | Transfer length in bytes |
| cfg_thresh_i | input | 5 | DMA threshold in words |
| cfg_starve_i | input | 4 | Host completions before the engine is forced in |
| busy_o | output | 1 | Engine transfers remain |
| dma_req_o | output | 1 | DMA service request |
| sys_wr_i | input | 1 | DMA write into FIFO (posting) |
| sys_wdata_i | input | 32 | DMA write data |
| sys_rd_i | input | 1 | DMA read from FIFO (prefetch) |
| sys_rdata_o | output | 32 | FIFO head word |
| host_req_i | input | 1 | Host access request, held until granted |
| host_cs_i | input | 3 | Host chip-select |
| host_we_i | input | 1 | Host write enable |
| host_gnt_o | output | 1 | Host access completes this cycle |
| acc_req_o | output | 1 | Access request to the access engine |
| acc_cs_o | output | 3 | Chip-select of the current access |
| acc_we_o | output | 1 | Write enable of the current access |
| acc_wdata_o | output | 32 | Engine write data |
| acc_rdata_i | input | 32 | Read data from the access engine |
| acc_ack_i | input | 1 | Access engine acknowledge |

## Verification
The hardest state to reach is the starvation override: the engine is eligible, a host request is pending, and the count of host completions has just reached the limit. That needs sustained host pressure together with a FIFO state that keeps the engine eligible. Directed runs therefore hold host_req_i high on every cycle with immediate acknowledges, at limits 3 and 0. Random runs mix host traffic, acknowledge delays and a slow DMA consumer, so that the engine also hits the full-FIFO stall at the same time as host contention.

// File: rtl/sppe_pkg.sv
`timescale 1ns/1ps
package sppe_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_ENG  = 2'd2
  } owner_e;

  typedef enum logic {
    MODE_PREFETCH = 1'b0,
    MODE_POST     = 1'b1
  } mode_e;
endpackage

// File: rtl/sppe_fifo.sv
`timescale 1ns/1ps
module sppe_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || clr_i));

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (!empty_o || clr_i));
endmodule

// File: rtl/sppe_arb.sv
`timescale 1ns/1ps
module sppe_arb
  import sppe_pkg::*;
#(
  parameter int CS_W     = 3,
  parameter int STARVE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_req_i,
  input  logic [CS_W-1:0]     host_cs_i,
  input  logic                host_we_i,
  input  logic                eng_req_i,
  input  logic [CS_W-1:0]     eng_cs_i,
  input  logic                eng_we_i,
  input  logic [STARVE_W-1:0] starve_lim_i,
  input  logic                acc_ack_i,
  output logic                acc_req_o,
  output logic [CS_W-1:0]     acc_cs_o,
  output logic                acc_we_o,
  output logic                host_gnt_o,
  output logic                eng_xfer_o
);
  owner_e              owner_q;
  logic [CS_W-1:0]     cs_q;
  logic                we_q;
  logic [STARVE_W-1:0] starve_q;
  logic                pick_eng, idle, host_done;

  assign idle      = (owner_q == OWN_IDLE);
  // engine wins when host is absent or has been favoured long enough
  assign pick_eng  = eng_req_i && (!host_req_i || (starve_q >= starve_lim_i));
  assign host_done = (owner_q == OWN_HOST) && acc_ack_i;

  assign acc_req_o  = !idle;
  assign acc_cs_o   = cs_q;
  assign acc_we_o   = we_q;
  assign host_gnt_o = host_done;
  assign eng_xfer_o = (owner_q == OWN_ENG) && acc_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_IDLE;
      cs_q     <= '0;
      we_q     <= 1'b0;
      starve_q <= '0;
    end else begin
      if (idle) begin
        if (pick_eng) begin
          owner_q <= OWN_ENG;
          cs_q    <= eng_cs_i;
          we_q    <= eng_we_i;
        end else if (host_req_i) begin
          owner_q <= OWN_HOST;
          cs_q    <= host_cs_i;
          we_q    <= host_we_i;
        end
      end else if (acc_ack_i) begin
        owner_q <= OWN_IDLE;
      end

      if (idle && pick_eng) starve_q <= '0;
      else if (host_done && eng_req_i && (starve_q != '1)) starve_q <= starve_q + 1'b1;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && !acc_ack_i) |=> (acc_req_o && $stable(acc_cs_o) && $stable(acc_we_o)));

  // R5
  idle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && acc_ack_i) |=> !acc_req_o);

  // R5
  starve_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_req_o && eng_req_i && host_req_i && (starve_q >= starve_lim_i))
      |=> (acc_req_o && (owner_q == OWN_ENG)));

  // R4
  one_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_gnt_o && eng_xfer_o));
endmodule

// File: rtl/sppe_ctrl.sv
`timescale 1ns/1ps
module sppe_ctrl
  import sppe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CS_W   = 3,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 16,
  parameter int TH_W   = 5,
  localparam int BSH   = $clog2(DATA_W / 8),
  localparam int WW    = CNT_W - BSH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [CNT_W-1:0]  bytes_i,
  input  logic [TH_W-1:0]   thresh_i,
  input  logic              sys_wr_i,
  input  logic [DATA_W-1:0] sys_wdata_i,
  input  logic              sys_rd_i,
  input  logic              eng_xfer_i,
  input  logic [DATA_W-1:0] acc_rdata_i,
  input  logic [TH_W-1:0]   fifo_cnt_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  output logic              fifo_clr_o,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              fifo_pop_o,
  output logic              eng_req_o,
  output logic [CS_W-1:0]   eng_cs_o,
  output logic              eng_we_o,
  output logic              busy_o,
  output logic              dma_req_o
);
  mode_e           mode_q;
  logic [CS_W-1:0] cs_q;
  logic [WW-1:0]   rem_q, push_left_q, words;
  logic            start_ok, is_post, sys_push;
  logic [TH_W-1:0] eff_th, free_sp;

  assign words    = bytes_i[CNT_W-1:BSH];
  assign start_ok = start_i && (rem_q == '0) && (words != '0);
  assign is_post  = (mode_q == MODE_POST);
  assign busy_o   = (rem_q != '0);

  assign sys_push     = is_post && sys_wr_i && (push_left_q != '0) && !fifo_full_i;
  assign fifo_clr_o   = start_ok;
  assign fifo_push_o  = is_post ? sys_push : eng_xfer_i;
  assign fifo_wdata_o = is_post ? sys_wdata_i : acc_rdata_i;
  assign fifo_pop_o   = is_post ? eng_xfer_i : (sys_rd_i && !fifo_empty_i);

  assign eng_req_o = busy_o && (is_post ? !fifo_empty_i : !fifo_full_i);
  assign eng_cs_o  = cs_q;
  assign eng_we_o  = is_post;

  assign eff_th  = (thresh_i == '0) ? TH_W'(1) : thresh_i;
  assign free_sp = TH_W'(DEPTH) - fifo_cnt_i;

  always_comb begin
    if (is_post) dma_req_o = (push_left_q != '0) && (free_sp >= eff_th);
    else         dma_req_o = (fifo_cnt_i >= eff_th) || (!busy_o && !fifo_empty_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_PREFETCH;
      cs_q        <= '0;
      rem_q       <= '0;
      push_left_q <= '0;
    end else if (start_ok) begin
      mode_q      <= mode_e'(mode_i);
      cs_q        <= cs_i;
      rem_q       <= words;
      push_left_q <= words;
    end else begin
      if (eng_xfer_i) rem_q <= rem_q - 1'b1;
      if (sys_push)   push_left_q <= push_left_q - 1'b1;
    end
  end

  // R10
  done_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(eng_xfer_i));

  // R2
  start_busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> ((mode_q == $past(mode_q)) && (cs_q == $past(cs_q))));

  // R10
  xfer_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_xfer_i |-> busy_o);
endmodule

// File: rtl/stream_prefetch_post.sv
`timescale 1ns/1ps
module stream_prefetch_post #(
  parameter int DATA_W     = 32,
  parameter int FIFO_BYTES = 64,
  parameter int CS_W       = 3,
  parameter int CNT_W      = 16,
  parameter int STARVE_W   = 4,
  localparam int DEPTH     = FIFO_BYTES / (DATA_W / 8),
  localparam int TH_W      = $clog2(DEPTH) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_start_i,
  input  logic                cfg_mode_i,
  input  logic [CS_W-1:0]     cfg_cs_i,
  input  logic [CNT_W-1:0]    cfg_bytes_i,
  input  logic [TH_W-1:0]     cfg_thresh_i,
  input  logic [STARVE_W-1:0] cfg_starve_i,
  output logic                busy_o,
  output logic                dma_req_o,
  input  logic                sys_wr_i,
  input  logic [DATA_W-1:0]   sys_wdata_i,
  input  logic                sys_rd_i,
  output logic [DATA_W-1:0]   sys_rdata_o,
  input  logic                host_req_i,
  input  logic [CS_W-1:0]     host_cs_i,
  input  logic                host_we_i,
  output logic                host_gnt_o,
  output logic                acc_req_o,
  output logic [CS_W-1:0]     acc_cs_o,
  output logic                acc_we_o,
  output logic [DATA_W-1:0]   acc_wdata_o,
  input  logic [DATA_W-1:0]   acc_rdata_i,
  input  logic                acc_ack_i
);
  logic              fifo_clr, fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DATA_W-1:0] fifo_wdata, fifo_head;
  logic [TH_W-1:0]   fifo_cnt;
  logic              eng_req, eng_we, eng_xfer;
  logic [CS_W-1:0]   eng_cs;

  assign sys_rdata_o = fifo_head;
  assign acc_wdata_o = fifo_head;

  sppe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (fifo_clr),
    .push_i      (fifo_push),
    .push_data_i (fifo_wdata),
    .pop_i       (fifo_pop),
    .head_o      (fifo_head),
    .count_o     (fifo_cnt),
    .full_o      (fifo_full),
    .empty_o     (fifo_empty)
  );

  sppe_ctrl #(
    .DATA_W(DATA_W), .CS_W(CS_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .TH_W(TH_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (cfg_start_i),
    .mode_i       (cfg_mode_i),
    .cs_i         (cfg_cs_i),
    .bytes_i      (cfg_bytes_i),
    .thresh_i     (cfg_thresh_i),
    .sys_wr_i     (sys_wr_i),
    .sys_wdata_i  (sys_wdata_i),
    .sys_rd_i     (sys_rd_i),
    .eng_xfer_i   (eng_xfer),
    .acc_rdata_i  (acc_rdata_i),
    .fifo_cnt_i   (fifo_cnt),
    .fifo_full_i  (fifo_full),
    .fifo_empty_i (fifo_empty),
    .fifo_clr_o   (fifo_clr),
    .fifo_push_o  (fifo_push),
    .fifo_wdata_o (fifo_wdata),
    .fifo_pop_o   (fifo_pop),
    .eng_req_o    (eng_req),
    .eng_cs_o     (eng_cs),
    .eng_we_o     (eng_we),
    .busy_o       (busy_o),
    .dma_req_o    (dma_req_o)
  );

  sppe_arb #(.CS_W(CS_W), .STARVE_W(STARVE_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_req_i   (host_req_i),
    .host_cs_i    (host_cs_i),
    .host_we_i    (host_we_i),
    .eng_req_i    (eng_req),
    .eng_cs_i     (eng_cs),
    .eng_we_i     (eng_we),
    .starve_lim_i (cfg_starve_i),
    .acc_ack_i    (acc_ack_i),
    .acc_req_o    (acc_req_o),
    .acc_cs_o     (acc_cs_o),
    .acc_we_o     (acc_we_o),
    .host_gnt_o   (host_gnt_o),
    .eng_xfer_o   (eng_xfer)
  );
endmodule

// File: tb/stream_prefetch_post_bench.sv
`timescale 1ns/1ps
module stream_prefetch_post_bench;
  localparam int DEPTH = 16;

  logic        clk, rst_n;
  logic        cfg_start_i, cfg_mode_i;
  logic [2:0]  cfg_cs_i;
  logic [15:0] cfg_bytes_i;
  logic [4:0]  cfg_thresh_i;
  logic [3:0]  cfg_starve_i;
  logic        busy_o, dma_req_o;
  logic        sys_wr_i, sys_rd_i;
  logic [31:0] sys_wdata_i, sys_rdata_o;
  logic        host_req_i, host_we_i, host_gnt_o;
  logic [2:0]  host_cs_i;
  logic        acc_req_o, acc_we_o, acc_ack_i;
  logic [2:0]  acc_cs_o;
  logic [31:0] acc_wdata_o, acc_rdata_i;

  stream_prefetch_post u_stream_prefetch_post (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_start_i(cfg_start_i), .cfg_mode_i(cfg_mode_i), .cfg_cs_i(cfg_cs_i),
    .cfg_bytes_i(cfg_bytes_i), .cfg_thresh_i(cfg_thresh_i), .cfg_starve_i(cfg_starve_i),
    .busy_o(busy_o), .dma_req_o(dma_req_o),
    .sys_wr_i(sys_wr_i), .sys_wdata_i(sys_wdata_i), .sys_rd_i(sys_rd_i), .sys_rdata_o(sys_rdata_o),
    .host_req_i(host_req_i), .host_cs_i(host_cs_i), .host_we_i(host_we_i), .host_gnt_o(host_gnt_o),
    .acc_req_o(acc_req_o), .acc_cs_o(acc_cs_o), .acc_we_o(acc_we_o),
    .acc_wdata_o(acc_wdata_o), .acc_rdata_i(acc_rdata_i), .acc_ack_i(acc_ack_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference state
  logic [31:0] q[$];
  int   m_rem = 0, m_pl = 0, m_owner = 0, m_starve = 0, eng_cnt = 0;
  bit   m_mode = 0, host_pend = 0, h_we_exp = 0;
  logic [2:0] m_cs = 0, h_cs_exp = 0;
  int   rd_idx = 0, wr_idx = 0, full_seen = 0;
  int   host_rate = 0, ack_rate = 100, dma_rate = 50, noise_rate = 0;
  bit   do_start = 0, st_mode = 0;
  int   st_bytes = 0;
  logic [2:0] st_cs = 0;

  function automatic logic [31:0] pf_word(input int k);
    return 32'h5A00_0000 ^ (32'(k) * 32'h0001_0203);
  endfunction

  function automatic logic [31:0] post_word(input int k);
    return 32'hC300_0000 + 32'(k) * 32'd7;
  endfunction

  function automatic bit exp_dma();
    int eff;
    eff = (cfg_thresh_i == 0) ? 1 : int'(cfg_thresh_i);
    if (!m_mode) return (q.size() >= eff) || (m_rem == 0 && q.size() != 0);
    return (m_pl != 0) && ((DEPTH - q.size()) >= eff);
  endfunction

  task automatic step();
    int  c0, rem0, st0;
    bit  eng_req_m, eng_x, host_x;
    @(negedge clk);
    chk(busy_o == (m_rem != 0), "R10 busy", busy_o, m_rem != 0);
    chk(dma_req_o == exp_dma(), m_mode ? "R9 dma_req" : "R8 dma_req", dma_req_o, exp_dma());
    chk(acc_req_o == (m_owner != 0), "R5 acc_req", acc_req_o, m_owner != 0);
    if (m_owner == 2)
      chk(acc_cs_o == m_cs && acc_we_o == m_mode, "R3 engine target",
          {acc_we_o, acc_cs_o}, {m_mode, m_cs});
    if (m_owner == 1)
      chk(acc_cs_o == h_cs_exp && acc_we_o == h_we_exp, "R3 host target",
          {acc_we_o, acc_cs_o}, {h_we_exp, h_cs_exp});
    if (q.size() == DEPTH && m_rem != 0 && !m_mode) full_seen++;

    if (!host_pend && ($urandom_range(99) < host_rate)) begin
      host_pend = 1;
      host_cs_i = 3'($urandom);
      host_we_i = 1'($urandom);
    end
    host_req_i  = host_pend;
    acc_ack_i   = acc_req_o && ($urandom_range(99) < ack_rate);
    acc_rdata_i = pf_word(rd_idx);
    if (!m_mode) begin
      sys_rd_i = (dma_req_o && ($urandom_range(99) < dma_rate)) || ($urandom_range(99) < noise_rate);
      sys_wr_i = ($urandom_range(99) < noise_rate);
    end else begin
      sys_wr_i = (dma_req_o && ($urandom_range(99) < dma_rate)) || ($urandom_range(99) < noise_rate);
      sys_rd_i = ($urandom_range(99) < noise_rate);
    end
    sys_wdata_i = post_word(wr_idx);
    cfg_start_i = do_start;
    cfg_mode_i  = st_mode;
    cfg_bytes_i = 16'(st_bytes);
    cfg_cs_i    = st_cs;
    #1;
    chk(host_gnt_o == (m_owner == 1 && acc_ack_i), "R4 host grant", host_gnt_o, m_owner == 1 && acc_ack_i);
    if (!m_mode && sys_rd_i && q.size() != 0)
      chk(sys_rdata_o == q[0], "R6 read order", sys_rdata_o, q[0]);
    if (m_mode && m_owner == 2 && acc_ack_i)
      chk(acc_wdata_o == q[0], "R7 post order", acc_wdata_o, q[0]);

    c0 = q.size(); rem0 = m_rem; st0 = m_starve;
    eng_req_m = (m_rem != 0) && (m_mode ? (c0 != 0) : (c0 != DEPTH));
    eng_x  = (m_owner == 2) && acc_ack_i;
    host_x = (m_owner == 1) && acc_ack_i;

    if (!m_mode && sys_rd_i && c0 != 0) void'(q.pop_front());
    if (m_mode && eng_x) void'(q.pop_front());
    if (!m_mode && eng_x) begin q.push_back(acc_rdata_i); rd_idx++; end
    if (m_mode && sys_wr_i && m_pl != 0 && c0 != DEPTH) begin
      q.push_back(sys_wdata_i); wr_idx++; m_pl--;
    end
    if (eng_x) begin m_rem--; eng_cnt++; end

    if (m_owner == 0) begin
      if (eng_req_m && (!host_req_i || st0 >= int'(cfg_starve_i))) begin
        m_owner = 2; m_starve = 0;
      end else if (host_req_i) begin
        m_owner = 1; h_cs_exp = host_cs_i; h_we_exp = host_we_i;
      end
    end else if (acc_ack_i) m_owner = 0;
    if (host_x && eng_req_m && st0 < 15) m_starve = st0 + 1;
    if (host_x) host_pend = 0;

    if (do_start && rem0 == 0 && (st_bytes >> 2) != 0) begin
      m_mode = st_mode; m_cs = st_cs; m_rem = st_bytes >> 2; m_pl = st_bytes >> 2;
      q.delete(); rd_idx = 0; wr_idx = 0; eng_cnt = 0;
    end
    do_start = 0;
  endtask

  task automatic run(input bit mode, input int bytes, input int th, input int lim,
                     input int hr, input int ar, input int dr, input int nr);
    int guard;
    cfg_thresh_i = 5'(th); cfg_starve_i = 4'(lim);
    host_rate = hr; ack_rate = ar; dma_rate = dr; noise_rate = nr;
    st_mode = mode; st_bytes = bytes; st_cs = 3'($urandom); do_start = 1;
    step();
    guard = 0;
    while ((m_rem != 0 || (!m_mode && q.size() != 0) || host_pend || m_owner != 0) && guard < 20000) begin
      step(); guard++;
    end
    host_rate = 0;
    chk(eng_cnt == (bytes >> 2), "R10 transfer count", eng_cnt, bytes >> 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; cfg_start_i = 0; cfg_mode_i = 0; cfg_cs_i = 0; cfg_bytes_i = 0;
    cfg_thresh_i = 4; cfg_starve_i = 2; sys_wr_i = 0; sys_rd_i = 0; sys_wdata_i = 0;
    host_req_i = 0; host_cs_i = 0; host_we_i = 0; acc_ack_i = 0; acc_rdata_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy_o, dma_req_o, acc_req_o, host_gnt_o} == 4'b0, "R1 reset outputs",
        {busy_o, dma_req_o, acc_req_o, host_gnt_o}, 0);
    rst_n = 1;

    // R2 zero word count ignored
    st_mode = 1; st_bytes = 3; do_start = 1;
    step(); step();
    chk(busy_o == 0, "R2 zero count ignored", busy_o, 0);

    // R6 R8 prefetch with host traffic
    run(0, 128, 4, 2, 30, 70, 60, 5);
    // R6 slow consumer fills the FIFO
    full_seen = 0;
    run(0, 96, 3, 1, 20, 90, 4, 0);
    chk(full_seen > 0, "R6 full stall reached", full_seen, 1);

    // R2 start while busy ignored, mid posting run
    cfg_thresh_i = 8; cfg_starve_i = 2; host_rate = 25; ack_rate = 60; dma_rate = 50; noise_rate = 5;
    st_mode = 1; st_bytes = 100; st_cs = 3'd5; do_start = 1;
    step();
    repeat (10) step();
    st_mode = 0; st_bytes = 8; st_cs = 3'd2; do_start = 1;
    step();
    chk(busy_o == 1 && m_mode == 1, "R2 start while busy ignored", busy_o, 1);
    while (m_rem != 0 || host_pend || m_owner != 0) step();
    chk(eng_cnt == 25, "R10 transfer count after ignored start", eng_cnt, 25);

    // R5 starvation override with constant host pressure
    run(1, 64, 4, 3, 100, 100, 80, 0);
    run(0, 64, 2, 0, 100, 100, 80, 0);
    // R9 posting, threshold above remaining words, noisy writes
    run(1, 20, 12, 5, 40, 50, 90, 20);
    // R8 threshold zero treated as one
    run(0, 40, 0, 4, 10, 80, 30, 10);

    for (int i = 0; i < 6; i++)
      run(1'($urandom), 4 * (1 + $urandom_range(47)) + $urandom_range(3), $urandom_range(17),
          $urandom_range(15), $urandom_range(100), 20 + $urandom_range(80),
          10 + $urandom_range(90), $urandom_range(20));

    repeat (3) step();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule